// File: doc/BRIEF.md
# IDE Task-File Register Window with Data-Port Byte Swap

This block is a memory-mapped slave that places an IDE task-file register set inside a 4 KB address window. Each register occupies a 16-byte slot, so the register index is taken from address bits 11:4. Address bits 3:0 and all bits above bit 11 are ignored. The host issues single-cycle requests with a 2-bit size code (0 = byte, 1 = halfword, 2 = word, 3 = reserved). Read data is registered and appears one clock after the request, qualified by `rvalid`.

Byte accesses reach the command-block registers at indices 1 to 7 and the device-control register. The device-control register is aliased at both index 8 and index 22. Halfword and word accesses reach only the data port at index 0. The bytes of such an access are reversed on their way to and from the drive-side data bus. Any access that has no target reads as all ones for its width and is discarded on write.

A drive-side interface supplies the error and status bytes, the data-port read value and an interrupt-set pulse. The block holds a pending-interrupt flag, which a read of the primary status register clears. A synchronous reset clears the register file, the interrupt flag and the read path.

Top module: `ide_regwin`

## Requirements
- R1: After synchronous reset, `rdata` is 0, `rvalid` is 0, `irq` is 0 and `feature`, `command` and `control` are 0.
- R2: The register index is `addr[11:4]`. Address bits 3:0 and the bits above bit 11 do not affect which register is reached.
- R3: A byte write to an index from 1 to 7 stores `wdata[7:0]` in that register. Index 1 drives `feature` and index 7 drives `command`. A byte read of an index from 2 to 6 returns the stored value in `rdata[7:0]`, with the upper bits zero.
- R4: A byte read of index 1 returns `dev_error`. A byte read of index 7 returns `dev_status`.
- R5: Byte writes to index 8 and to index 22 both load `control`. Byte reads of either index return `dev_status` and leave `irq` unchanged.
- R6: A byte read of any other index returns 0x000000FF. A byte write to any other index changes no register.
- R7: Halfword and word accesses reach only index 0. Elsewhere, a halfword read returns 0x0000FFFF, a word read or a size-3 read returns 0xFFFFFFFF, a write is dropped, and `dport_rd` and `dport_wr` stay low.
- R8: A halfword data-port access swaps the two low bytes in both directions. Written value 0xABCD appears on `dport_wdata` as 0x0000CDAB. A drive value with low half 0x5678 reads as 0x00007856. `dport_word` is 0.
- R9: A word data-port access reverses all four bytes in both directions, and `dport_word` is 1.
- R10: An `irq_set` pulse makes `irq` 1 on the next clock. A byte read of index 7 clears it on the next clock, unless `irq_set` is high in the same cycle, in which case `irq` stays 1.
- R11: `rvalid` is 1 exactly one clock after each read request. `rdata` then holds that read's value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | AW | Byte address; bits 11:4 select the register |
| wdata | input | 32 | Write data, byte in bits 7:0 |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one clock after the read |
| dev_status | input | 8 | Drive status byte |
| dev_error | input | 8 | Drive error byte |
| irq_set | input | 1 | Drive raises an interrupt request |
| irq | output | 1 | Pending interrupt request |
| feature | output | 8 | Feature register value |
| command | output | 8 | Command register value |
| control | output | 8 | Device-control register value |
| dport_rd | output | 1 | Data-port read strobe, same cycle as the request |
| dport_wr | output | 1 | Data-port write strobe, same cycle as the request |
| dport_word | output | 1 | Data-port access is a word (else halfword) |
| dport_wdata | output | 32 | Byte-swapped data toward the drive |
| dport_rdata | input | 32 | Data from the drive, in drive byte order |

## Verification
A wrong decode shows up at the ports in one of three ways. A stray strobe on the data-port lines appears in the same cycle as the request. A misplaced byte or a wrong all-ones pattern appears in `rdata` one clock later. A stray write is seen only later, when the register is read back or on the `feature`, `command` or `control` outputs. A fault in the interrupt flag shows on `irq` on the clock after the status or alternate-status read, so the two alias indices and the same-cycle set-and-clear case are each checked on the cycle right after the access.

// File: rtl/ide_regwin.sv
module ide_regwin #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          rvalid,
  input  logic [7:0]    dev_status,
  input  logic [7:0]    dev_error,
  input  logic          irq_set,
  output logic          irq,
  output logic [7:0]    feature,
  output logic [7:0]    command,
  output logic [7:0]    control,
  output logic          dport_rd,
  output logic          dport_wr,
  output logic          dport_word,
  output logic [31:0]   dport_wdata,
  input  logic [31:0]   dport_rdata
);
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = 8;
  localparam logic [IDX_W-1:0] CTL_A = 8'd8;
  localparam logic [IDX_W-1:0] CTL_B = 8'd22;

  function automatic logic [15:0] swap2(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [IDX_W-1:0] idx;
  logic [7:0]       tf_q [8];
  logic [7:0]       ctrl_q;
  logic             irq_q;
  logic [31:0]      rd_q;
  logic             rv_q;
  logic [31:0]      rd_next;

  assign idx = addr[IDX_LSB +: IDX_W];

  wire is_rd   = req & ~wr;
  wire is_wr   = req & wr;
  wire by_acc  = (size == 2'd0);
  wire tf_hit  = by_acc && (idx >= 8'd1) && (idx <= 8'd7);
  wire ctl_hit = by_acc && ((idx == CTL_A) || (idx == CTL_B));
  wire dp_hit  = ((size == 2'd1) || (size == 2'd2)) && (idx == '0);

  assign dport_rd    = is_rd & dp_hit;
  assign dport_wr    = is_wr & dp_hit;
  assign dport_word  = (size == 2'd2);
  assign dport_wdata = dport_word ? swap4(wdata) : {16'h0000, swap2(wdata[15:0])};

  always_comb begin
    if (tf_hit) begin
      if (idx == 8'd1)      rd_next = {24'h0, dev_error};
      else if (idx == 8'd7) rd_next = {24'h0, dev_status};
      else                  rd_next = {24'h0, tf_q[idx[2:0]]};
    end else if (ctl_hit)   rd_next = {24'h0, dev_status};
    else if (by_acc)        rd_next = 32'h0000_00FF;
    else if (dp_hit)        rd_next = dport_word ? swap4(dport_rdata)
                                                 : {16'h0000, swap2(dport_rdata[15:0])};
    else if (size == 2'd1)  rd_next = 32'h0000_FFFF;
    else                    rd_next = 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) tf_q[i] <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= is_rd;
      if (is_rd) rd_q <= rd_next;
      if (is_wr && tf_hit)  tf_q[idx[2:0]] <= wdata[7:0];
      if (is_wr && ctl_hit) ctrl_q <= wdata[7:0];
      if (irq_set)                              irq_q <= 1'b1;
      else if (is_rd && tf_hit && idx == 8'd7)  irq_q <= 1'b0;
    end
  end

  assign rdata   = rd_q;
  assign rvalid  = rv_q;
  assign irq     = irq_q;
  assign feature = tf_q[1];
  assign command = tf_q[7];
  assign control = ctrl_q;
endmodule

// File: rtl/ide_regwin_chk.sv
module ide_regwin_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          wr,
  input logic [1:0]    size,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic          rvalid,
  input logic          irq_set,
  input logic          irq,
  input logic          dport_rd,
  input logic          dport_wr,
  input logic [31:0]   dport_wdata
);
  wire [7:0] cidx  = addr[11:4];
  wire       rd_rq = req && !wr;

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_rq |=> rvalid);

  // R11
  idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_rq |=> !rvalid);

  // R7
  wide_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (req && size != 2'd0 && cidx != 8'd0) |-> (!dport_rd && !dport_wr));

  // R7
  wide_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rq && size == 2'd2 && cidx != 8'd0) |=> (rdata == 32'hFFFF_FFFF));

  // R9
  word_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (dport_wr && size == 2'd2) |->
      (dport_wdata == {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]}));

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rq && size == 2'd0 && cidx == 8'd7 && !irq_set) |=> !irq);

  // R5
  alt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && rd_rq && size == 2'd0 && (cidx == 8'd8 || cidx == 8'd22)) |=> irq);
endmodule

bind ide_regwin ide_regwin_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .wr(wr), .size(size), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq_set(irq_set),
  .irq(irq), .dport_rd(dport_rd), .dport_wr(dport_wr),
  .dport_wdata(dport_wdata)
);

// File: tb/ide_regwin_test.sv
module ide_regwin_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  dev_status = 8'h50;
  logic [7:0]  dev_error = 8'h44;
  logic        irq_set = 1'b0;
  logic        irq;
  logic [7:0]  feature, command, control;
  logic        dport_rd, dport_wr, dport_word;
  logic [31:0] dport_wdata;
  logic [31:0] dport_rdata = '0;

  int checks = 0;
  int fails = 0;
  logic s_rd, s_wr, s_word;
  logic [31:0] s_wdata;

  always #4 clk = ~clk;

  ide_regwin #(.AW(32)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; size = sz; addr = a; wdata = d;
    #1;
    s_rd = dport_rd; s_wr = dport_wr; s_word = dport_word; s_wdata = dport_wdata;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] exp);
    acc(1'b0, sz, a, '0);
    check(tag, rdata, exp);
    check("R11 rvalid", {31'b0, rvalid}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, '0);
    check("R1 rvalid", {31'b0, rvalid}, '0);
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 regs", {8'h0, feature, command, control}, '0);
  endtask

  task automatic t_taskfile;
    acc(1'b1, 2'd0, 32'h020, 32'h12);
    rd_chk("R3 idx2", 2'd0, 32'h020, 32'h12);
    acc(1'b1, 2'd0, 32'h060, 32'hA6);
    rd_chk("R3 idx6", 2'd0, 32'h060, 32'hA6);
    acc(1'b1, 2'd0, 32'h010, 32'h03);
    check("R3 feature", {24'h0, feature}, 32'h03);
    acc(1'b1, 2'd0, 32'h070, 32'hEC);
    check("R3 command", {24'h0, command}, 32'hEC);
    rd_chk("R4 error", 2'd0, 32'h010, 32'h44);
    rd_chk("R4 status", 2'd0, 32'h070, 32'h50);
    @(negedge clk);
    check("R11 rvalid drop", {31'b0, rvalid}, '0);
    check("R11 rdata hold", rdata, 32'h50);
  endtask

  task automatic t_alias;
    acc(1'b1, 2'd0, 32'hFFFF_F03C, 32'h77);
    rd_chk("R2 idx3 alias", 2'd0, 32'h035, 32'h77);
  endtask

  task automatic t_ctrl;
    acc(1'b1, 2'd0, 32'h080, 32'h02);
    check("R5 ctl idx8", {24'h0, control}, 32'h02);
    acc(1'b1, 2'd0, 32'h160, 32'h04);
    check("R5 ctl idx22", {24'h0, control}, 32'h04);
    dev_status = 8'h58;
    rd_chk("R5 alt idx22", 2'd0, 32'h160, 32'h58);
    rd_chk("R5 alt idx8", 2'd0, 32'h080, 32'h58);
    dev_status = 8'h50;
  endtask

  task automatic t_unmapped_byte;
    rd_chk("R6 idx0 byte", 2'd0, 32'h000, 32'hFF);
    rd_chk("R6 idx9", 2'd0, 32'h090, 32'hFF);
    acc(1'b1, 2'd0, 32'h090, 32'h99);
    acc(1'b1, 2'd0, 32'h000, 32'h99);
    check("R6 regs kept", {8'h0, feature, command, control}, 32'h0003EC04);
    rd_chk("R6 idx2 kept", 2'd0, 32'h020, 32'h12);
  endtask

  task automatic t_half;
    acc(1'b1, 2'd1, 32'h000, 32'h0000ABCD);
    check("R8 wr strobe", {30'b0, s_wr, s_word}, 32'b10);
    check("R8 wdata", s_wdata, 32'h0000CDAB);
    dport_rdata = 32'h12345678;
    acc(1'b0, 2'd1, 32'h000, '0);
    check("R8 rd strobe", {31'b0, s_rd}, 32'd1);
    check("R8 rdata", rdata, 32'h00007856);
  endtask

  task automatic t_word;
    acc(1'b1, 2'd2, 32'h000, 32'h11223344);
    check("R9 wr strobe", {30'b0, s_wr, s_word}, 32'b11);
    check("R9 wdata", s_wdata, 32'h44332211);
    dport_rdata = 32'hA1B2C3D4;
    acc(1'b0, 2'd2, 32'h000, '0);
    check("R9 rdata", rdata, 32'hD4C3B2A1);
  endtask

  task automatic t_wide_unmapped;
    acc(1'b0, 2'd1, 32'h020, '0);
    check("R7 half ones", rdata, 32'h0000FFFF);
    check("R7 no rd", {31'b0, s_rd}, '0);
    acc(1'b0, 2'd2, 32'h070, '0);
    check("R7 word ones", rdata, 32'hFFFFFFFF);
    acc(1'b1, 2'd2, 32'h020, 32'h55667788);
    check("R7 no wr", {31'b0, s_wr}, '0);
    rd_chk("R7 idx2 kept", 2'd0, 32'h020, 32'h12);
    acc(1'b0, 2'd3, 32'h000, '0);
    check("R7 size3", {rdata[31:1], s_rd}, 32'hFFFFFFFE);
  endtask

  task automatic t_irq;
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    check("R10 set", {31'b0, irq}, 32'd1);
    acc(1'b0, 2'd0, 32'h080, '0);
    check("R10 alt keeps", {31'b0, irq}, 32'd1);
    acc(1'b0, 2'd0, 32'h160, '0);
    check("R10 alt22 keeps", {31'b0, irq}, 32'd1);
    acc(1'b0, 2'd0, 32'h070, '0);
    check("R10 status clears", {31'b0, irq}, '0);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; size = 2'd0; addr = 32'h070; irq_set = 1'b1;
    @(negedge clk);
    req = 1'b0; irq_set = 1'b0;
    check("R10 set wins", {31'b0, irq}, 32'd1);
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_taskfile();
    t_alias();
    t_ctrl();
    t_unmapped_byte();
    t_half();
    t_word();
    t_wide_unmapped();
    t_irq();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule